// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a circular list of transmit buffer descriptors held in a descriptor memory. Software programs a ring base address, sets the enable input, and pulses the demand input. The walker then reads descriptors one after another. For every descriptor that software has marked ready, it produces one byte address per cycle covering the buffer and adds those bytes to a running frame length. It then writes the descriptor back with ready cleared and moves to the next entry. The walk ends at the first descriptor that is not ready, or when a per-demand visit limit is reached.

Each descriptor takes two 32-bit words. Word 0 holds the flags and the length: bit 31 is ready, bit 29 is wrap, bit 27 is last-in-frame and bits 15:0 are the length in bytes. Word 1 holds the byte address of the buffer. A descriptor with last set closes a frame. A frame that would grow past the size limit is clipped at that limit. The walker reports buffer completion, frame completion and babble as one-cycle events. Fetching the data bytes, inserting checksums and serialising the frame are done by neighbouring logic.

Top module: `txring_walker`

## Requirements
- R1: A demand pulse starts a walk only when enable is high and the walker is idle. `busy` is 1 from the cycle after the demand until the walk ends and 0 otherwise. A demand while enable is low has no effect.
- R2: The walk stops at the first descriptor whose word 0 bit 31 (ready) is 0. That descriptor is not written, and the next demand starts again from it.
- R3: For a ready descriptor, the walker asserts `byteValid` once per byte. `byteAddr` steps from the buffer address (word 1) upward, one cycle per byte, for the effective length. The length is taken from word 0 bits 15:0.
- R4: When a descriptor has last set (word 0 bit 27), the walker pulses `frameDone` and `evFrame`, and `frameLen` gives the total bytes of the frame. Otherwise it pulses `evBuf`. The frame length starts from zero at each demand and after each last descriptor.
- R5: If the frame length plus a descriptor's length would exceed MAX_FRAME, the effective length is cut to the room left and `evBabble` pulses with that descriptor's completion event.
- R6: After use, word 0 of the descriptor is written back with bit 31 cleared and every other bit unchanged.
- R7: After a descriptor, the pointer moves 8 bytes forward. If that descriptor's wrap bit (word 0 bit 29) is set, it returns to the ring base instead.
- R8: At most MAX_DESC descriptors are read in one walk. The first descriptor left unread keeps its ready bit and is read first on the next demand.
- R9: While enable is low the walker is idle, and its pointer is reloaded from the ring base. This also aborts a walk in progress.
- R10: A base write forces the low ALIGN_BITS bits of the address to zero. While idle, the write also moves the pointer to the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable |
| demandWr | input | 1 | Transmit demand pulse |
| baseWr | input | 1 | Ring base write strobe |
| baseData | input | 32 | Ring base address to write |
| busy | output | 1 | Demand status, 1 while walking |
| descRd | output | 1 | Descriptor memory read, data returned next cycle |
| descWr | output | 1 | Descriptor memory write |
| descAddr | output | 32 | Descriptor memory byte address |
| descWdata | output | 32 | Descriptor write data |
| descRdata | input | 32 | Descriptor read data |
| byteValid | output | 1 | Frame byte request valid |
| byteAddr | output | 32 | Address of the requested frame byte |
| frameDone | output | 1 | End-of-frame strobe |
| frameLen | output | $clog2(MAX_FRAME+1) | Frame length in bytes, valid with frameDone |
| evBuf | output | 1 | Buffer-done event |
| evFrame | output | 1 | Frame-done event |
| evBabble | output | 1 | Frame-clipped event |

## Verification
Several descriptor patterns are used. A two-buffer frame followed by a not-ready entry shows that bytes are concatenated across buffers and that the walk stops at the right entry. A single wrapping descriptor shows the walk resuming from the stopped entry and the return to the base. A long chain of ready descriptors tells the visit limit apart from a not-ready stop. A disable and re-enable shows the pointer reloading and the frame length restarting at zero. A frame longer than the limit tells clipping apart from normal completion, because the byte count, the final byte address and the babble event all differ.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int READY_BIT  = 31;
  localparam int WRAP_BIT   = 29;
  localparam int LAST_BIT   = 27;
  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_CHK, S_RD1, S_GETA, S_STREAM, S_WB
  } walkState_t;

  typedef struct packed {
    logic idle;
    logic reloadBase;
    logic frameClear;
    logic capW0;
    logic capW1;
    logic byteStep;
    logic advance;
  } dpCtl_t;
endpackage

// File: rtl/txring_dp.sv
module txring_dp
  import txring_pkg::*;
#(
  parameter int MAX_FRAME  = 2048,
  parameter int ALIGN_BITS = 3,
  parameter int LEN_W      = 16,
  localparam int FW        = $clog2(MAX_FRAME + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic          addrHi,
  input  logic          baseWr,
  input  logic [31:0]   baseData,
  input  logic [31:0]   descRdata,
  output logic [31:0]   descAddr,
  output logic [31:0]   descWdata,
  output logic [31:0]   byteAddr,
  output logic [FW-1:0] frameLen,
  output logic          descReady,
  output logic          lastFlag,
  output logic          babbleFlag,
  output logic          clipZero,
  output logic          streamLast
);
  localparam logic [31:0] ALIGN_MASK = ~((32'd1 << ALIGN_BITS) - 32'd1);
  localparam logic [31:0] MAX_F32    = 32'(MAX_FRAME);

  logic [31:0]      ptrQ, baseQ, word0Q, bufAddrQ;
  logic [LEN_W-1:0] remainQ, offsetQ;
  logic [FW-1:0]    frameQ;
  logic             babbleQ;

  logic [31:0] lenX, roomX, effX;
  logic        over;

  always_comb begin
    lenX  = 32'(word0Q[LEN_W-1:0]);
    roomX = MAX_F32 - 32'(frameQ);
    over  = lenX > roomX;
    effX  = over ? roomX : lenX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
    end else if (baseWr) begin
      baseQ <= baseData & ALIGN_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (baseWr && ctl.idle) begin
      ptrQ <= baseData & ALIGN_MASK;
    end else if (ctl.reloadBase) begin
      ptrQ <= baseQ;
    end else if (ctl.advance) begin
      ptrQ <= word0Q[WRAP_BIT] ? baseQ : ptrQ + 32'(DESC_BYTES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word0Q   <= '0;
      bufAddrQ <= '0;
      remainQ  <= '0;
      offsetQ  <= '0;
      babbleQ  <= 1'b0;
    end else begin
      if (ctl.capW0) word0Q <= descRdata;
      if (ctl.capW1) begin
        bufAddrQ <= descRdata;
        remainQ  <= effX[LEN_W-1:0];
        offsetQ  <= '0;
        babbleQ  <= over;
      end else if (ctl.byteStep) begin
        remainQ <= remainQ - 1'b1;
        offsetQ <= offsetQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ <= '0;
    end else if (ctl.frameClear) begin
      frameQ <= '0;
    end else if (ctl.byteStep) begin
      frameQ <= frameQ + 1'b1;
    end else if (ctl.advance && word0Q[LAST_BIT]) begin
      frameQ <= '0;
    end
  end

  assign descAddr   = ptrQ + (addrHi ? 32'd4 : 32'd0);
  assign descWdata  = word0Q & ~(32'd1 << READY_BIT);
  assign byteAddr   = bufAddrQ + 32'(offsetQ);
  assign frameLen   = frameQ;
  assign descReady  = descRdata[READY_BIT];
  assign lastFlag   = word0Q[LAST_BIT];
  assign babbleFlag = babbleQ;
  assign clipZero   = (effX == 32'd0);
  assign streamLast = (remainQ == LEN_W'(1));
endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
#(
  parameter int MAX_DESC = 1024,
  localparam int VW      = $clog2(MAX_DESC + 1)
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   enable,
  input  logic   demandWr,
  input  logic   descReady,
  input  logic   clipZero,
  input  logic   streamLast,
  input  logic   lastFlag,
  input  logic   babbleFlag,
  output dpCtl_t ctl,
  output logic   addrHi,
  output logic   busy,
  output logic   descRd,
  output logic   descWr,
  output logic   byteValid,
  output logic   frameDone,
  output logic   evBuf,
  output logic   evFrame,
  output logic   evBabble
);
  walkState_t stateQ, stateD;
  logic [VW-1:0] visitsQ;
  logic limitHit;

  assign limitHit = (visitsQ == VW'(MAX_DESC));

  always_comb begin
    stateD = stateQ;
    if (!enable) begin
      stateD = S_IDLE;
    end else begin
      case (stateQ)
        S_IDLE:   if (demandWr) stateD = S_RD0;
        S_RD0:    stateD = S_CHK;
        S_CHK:    stateD = descReady ? S_RD1 : S_IDLE;
        S_RD1:    stateD = S_GETA;
        S_GETA:   stateD = clipZero ? S_WB : S_STREAM;
        S_STREAM: if (streamLast) stateD = S_WB;
        S_WB:     stateD = limitHit ? S_IDLE : S_RD0;
        default:  stateD = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      visitsQ <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == S_IDLE) visitsQ <= '0;
      else if (stateQ == S_RD0) visitsQ <= visitsQ + 1'b1;
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.idle       = (stateQ == S_IDLE);
    ctl.reloadBase = !enable;
    ctl.frameClear = enable && (stateQ == S_IDLE) && demandWr;
    ctl.capW0      = (stateQ == S_CHK);
    ctl.capW1      = (stateQ == S_GETA);
    ctl.byteStep   = (stateQ == S_STREAM);
    ctl.advance    = enable && (stateQ == S_WB);
  end

  assign addrHi    = (stateQ == S_RD1);
  assign busy      = (stateQ != S_IDLE);
  assign descRd    = (stateQ == S_RD0) || (stateQ == S_RD1);
  assign descWr    = (stateQ == S_WB);
  assign byteValid = (stateQ == S_STREAM);
  assign frameDone = descWr && lastFlag;
  assign evFrame   = descWr && lastFlag;
  assign evBuf     = descWr && !lastFlag;
  assign evBabble  = descWr && babbleFlag;
endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txring_pkg::*;
#(
  parameter int MAX_FRAME  = 2048,
  parameter int MAX_DESC   = 1024,
  parameter int ALIGN_BITS = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           enable,
  input  logic                           demandWr,
  input  logic                           baseWr,
  input  logic [31:0]                    baseData,
  output logic                           busy,
  output logic                           descRd,
  output logic                           descWr,
  output logic [31:0]                    descAddr,
  output logic [31:0]                    descWdata,
  input  logic [31:0]                    descRdata,
  output logic                           byteValid,
  output logic [31:0]                    byteAddr,
  output logic                           frameDone,
  output logic [$clog2(MAX_FRAME+1)-1:0] frameLen,
  output logic                           evBuf,
  output logic                           evFrame,
  output logic                           evBabble
);
  dpCtl_t ctl;
  logic addrHi, descReady, lastFlag, babbleFlag, clipZero, streamLast;

  txring_ctrl #(.MAX_DESC(MAX_DESC)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .demandWr(demandWr),
    .descReady(descReady), .clipZero(clipZero), .streamLast(streamLast),
    .lastFlag(lastFlag), .babbleFlag(babbleFlag), .ctl(ctl),
    .addrHi(addrHi), .busy(busy), .descRd(descRd), .descWr(descWr),
    .byteValid(byteValid), .frameDone(frameDone), .evBuf(evBuf),
    .evFrame(evFrame), .evBabble(evBabble)
  );

  txring_dp #(.MAX_FRAME(MAX_FRAME), .ALIGN_BITS(ALIGN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrHi(addrHi), .baseWr(baseWr),
    .baseData(baseData), .descRdata(descRdata), .descAddr(descAddr),
    .descWdata(descWdata), .byteAddr(byteAddr), .frameLen(frameLen),
    .descReady(descReady), .lastFlag(lastFlag), .babbleFlag(babbleFlag),
    .clipZero(clipZero), .streamLast(streamLast)
  );
endmodule

// File: rtl/txring_chk.sv
module txring_chk (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        demandWr,
  input logic        busy,
  input logic        descRd,
  input logic        descWr,
  input logic [31:0] descAddr,
  input logic [31:0] descWdata,
  input logic        byteValid,
  input logic        evBuf,
  input logic        evFrame,
  input logic        evBabble
);
  // R1: demand while idle and enabled starts a walk
  a_r1_demand_starts: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && enable && demandWr) |=> busy);
  // R1: idle and disabled stays idle whatever the demand input does
  a_r1_ignore_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !enable) |=> !busy);
  // R9: disable aborts any walk
  a_r9_disable_stops: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);
  // R6: write-back always has ready cleared
  a_r6_wb_ready_clear: assert property (@(posedge clk) disable iff (!rstN)
    descWr |-> !descWdata[31]);
  // R4: at most one completion event per cycle
  a_r4_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evBuf, evFrame}));
  // R5: babble only accompanies a descriptor write-back
  a_r5_babble_with_wb: assert property (@(posedge clk) disable iff (!rstN)
    evBabble |-> descWr);
  // R3: byte requests never overlap descriptor accesses
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({byteValid, descRd, descWr}));
  // R10: descriptor accesses are word aligned
  a_r10_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (descRd || descWr) |-> (descAddr[1:0] == 2'b00));
endmodule

bind txring_walker txring_chk u_chk (.*);

// File: tb/tb_txring_walker.sv
module tb_txring_walker;
  localparam int MAXF = 40;
  localparam int MAXD = 6;
  localparam int FW   = $clog2(MAXF + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, demandWr = 1'b0, baseWr = 1'b0;
  logic [31:0] baseData = '0;
  logic busy, descRd, descWr, byteValid, frameDone, evBuf, evFrame, evBabble;
  logic [31:0] descAddr, descWdata, descRdata, byteAddr;
  logic [FW-1:0] frameLen;

  always #2 clk = ~clk;

  txring_walker #(.MAX_FRAME(MAXF), .MAX_DESC(MAXD), .ALIGN_BITS(3)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .demandWr(demandWr),
    .baseWr(baseWr), .baseData(baseData), .busy(busy), .descRd(descRd),
    .descWr(descWr), .descAddr(descAddr), .descWdata(descWdata),
    .descRdata(descRdata), .byteValid(byteValid), .byteAddr(byteAddr),
    .frameDone(frameDone), .frameLen(frameLen), .evBuf(evBuf),
    .evFrame(evFrame), .evBabble(evBabble)
  );

  logic [31:0] mem [0:63];
  always @(posedge clk) begin
    if (descRd) descRdata <= mem[descAddr[7:2]];
    if (descWr) mem[descAddr[7:2]] <= descWdata;
  end

  int nTests = 0, nFail = 0;
  int byteN, rdN, frameN, bufN, frmN, babN, lastLen;
  logic [31:0] byteLog [0:63];
  logic [31:0] rdLog [0:15];

  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid) begin
        if (byteN < 64) byteLog[byteN] = byteAddr;
        byteN++;
      end
      if (descRd && !descAddr[2]) begin
        if (rdN < 16) rdLog[rdN] = descAddr;
        rdN++;
      end
      if (frameDone) begin frameN++; lastLen = int'(frameLen); end
      if (evBuf) bufN++;
      if (evFrame) frmN++;
      if (evBabble) babN++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nTests++; nFail++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 20000)", cyc);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    byteN = 0; rdN = 0; frameN = 0; bufN = 0; frmN = 0; babN = 0; lastLen = -1;
  endtask

  function automatic logic [31:0] w0(bit rdy, bit wrp, bit lst, int len);
    return {rdy, 1'b0, wrp, 1'b0, lst, 11'b0, 16'(len)};
  endfunction

  task automatic setDesc(int idx, bit rdy, bit wrp, bit lst, int len, logic [31:0] a);
    mem[8 + 2*idx]     = w0(rdy, wrp, lst, len);
    mem[8 + 2*idx + 1] = a;
  endtask

  task automatic demand();
    @(negedge clk); demandWr = 1'b1;
    @(negedge clk); demandWr = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    check(!busy, tag, busy, 0);
  endtask

  task automatic t_reset();
    check(!busy, "R1 reset busy", busy, 0);
    check(!descRd && !descWr && !byteValid, "R1 reset idle ports",
          {descRd, descWr, byteValid}, 0);
  endtask

  task automatic t_disabled_demand();
    clearLog();
    enable = 1'b0;
    demand();
    repeat (5) @(negedge clk);
    check(!busy, "R1 demand while disabled busy", busy, 0);
    check(rdN == 0, "R1 demand while disabled reads", rdN, 0);
  endtask

  task automatic t_single_frame();
    @(negedge clk); baseWr = 1'b1; baseData = 32'h27;
    @(negedge clk); baseWr = 1'b0; enable = 1'b1;
    setDesc(0, 1, 0, 0, 3, 32'h1000);
    setDesc(1, 1, 0, 1, 2, 32'h2000);
    setDesc(2, 0, 0, 0, 0, 32'h0);
    clearLog();
    demand();
    check(busy, "R1 busy while walking", busy, 1);
    waitIdle("R1 busy clears");
    check(rdN == 3, "R2 read count", rdN, 3);
    check(rdLog[0] == 32'h20, "R10 aligned base", rdLog[0], 32'h20);
    check(rdLog[1] == 32'h28 && rdLog[2] == 32'h30, "R7 step 8", rdLog[2], 32'h30);
    check(byteN == 5, "R3 byte count", byteN, 5);
    check(byteLog[0] == 32'h1000 && byteLog[2] == 32'h1002 && byteLog[3] == 32'h2000
          && byteLog[4] == 32'h2001, "R3 byte addresses", byteLog[4], 32'h2001);
    check(frameN == 1 && lastLen == 5, "R4 frame length", lastLen, 5);
    check(bufN == 1 && frmN == 1, "R4 event counts", {bufN, frmN}, {32'd1, 32'd1});
    check(mem[8] == w0(0, 0, 0, 3), "R6 writeback", mem[8], w0(0, 0, 0, 3));
    check(mem[10] == w0(0, 0, 1, 2), "R6 writeback last", mem[10], w0(0, 0, 1, 2));
    check(mem[12] == 32'h0, "R2 not-ready untouched", mem[12], 0);
  endtask

  task automatic t_resume_wrap();
    setDesc(2, 1, 1, 1, 1, 32'h3000);
    clearLog();
    demand();
    waitIdle("R2 resume idle");
    check(rdN == 2 && rdLog[0] == 32'h30, "R2 resume point", rdLog[0], 32'h30);
    check(rdLog[1] == 32'h20, "R7 wrap to base", rdLog[1], 32'h20);
    check(byteN == 1 && byteLog[0] == 32'h3000, "R3 single byte", byteLog[0], 32'h3000);
    check(frameN == 1 && lastLen == 1, "R4 one-byte frame", lastLen, 1);
  endtask

  task automatic t_limit();
    for (int i = 0; i < 8; i++) setDesc(i, 1, i == 7, 0, 1, 32'h100 + i);
    clearLog();
    demand();
    waitIdle("R8 limit idle");
    check(rdN == MAXD, "R8 visit limit", rdN, MAXD);
    check(byteN == MAXD && bufN == MAXD && frmN == 0, "R8 buffers done", bufN, MAXD);
    check(mem[8 + 2*MAXD][31] == 1'b1, "R8 next left ready", mem[8 + 2*MAXD][31], 1);
    check(mem[8 + 2*(MAXD-1)][31] == 1'b0, "R6 last visited cleared",
          mem[8 + 2*(MAXD-1)][31], 0);
  endtask

  task automatic t_disable_reload();
    @(negedge clk); enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    setDesc(0, 1, 0, 1, 4, 32'h4000);
    setDesc(1, 0, 0, 0, 0, 32'h0);
    clearLog();
    demand();
    waitIdle("R9 idle");
    check(rdLog[0] == 32'h20, "R9 pointer reloaded", rdLog[0], 32'h20);
    check(frameN == 1 && lastLen == 4, "R4 length restarts per demand", lastLen, 4);
    check(babN == 0, "R5 no babble on short frame", babN, 0);
  endtask

  task automatic t_babble();
    setDesc(1, 1, 0, 0, 30, 32'h5000);
    setDesc(2, 1, 0, 1, 20, 32'h6000);
    setDesc(3, 0, 0, 0, 0, 32'h0);
    clearLog();
    demand();
    waitIdle("R5 idle");
    check(byteN == MAXF, "R5 clipped byte count", byteN, MAXF);
    check(byteLog[MAXF-1] == 32'h6009, "R5 last clipped byte", byteLog[MAXF-1], 32'h6009);
    check(frameN == 1 && lastLen == MAXF, "R5 frame length at limit", lastLen, MAXF);
    check(babN == 1, "R5 babble event", babN, 1);
    check(bufN == 1 && frmN == 1, "R4 events with babble", {bufN, frmN}, {32'd1, 32'd1});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    descRdata = '0;
    clearLog();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_demand();
    t_single_frame();
    t_resume_wrap();
    t_limit();
    t_disable_reload();
    t_babble();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule